// File: doc/BRIEF.md
# Register Access Protection Checker

This block sits between a register bus and a window of 32-bit registers. Each access is classified before it reaches the register file. The block checks whether the target lies inside the window. It checks whether the target's protection bit allows unprivileged and non-secure callers. It also checks whether the access direction suits the register, since some registers are read-only and others write-only. An access that passes every check is granted, and the register file sees it in the same cycle. An access that fails is denied: the write strobe stays low and read data comes back as zero.

Every denied access sets one or more bits in a ten-bit cause register. The first fault after an idle period also latches its address. Software reads the cause and the address through a configuration port. It acknowledges a fault by writing the cause value back, since the cause bits are write-one-to-clear. The same port loads the protection bitmap, either as whole 32-bit words or by opening a single register given its byte offset. An interrupt stays high while any cause bit is set.

Top module: `regguard_top`

## Requirements
- R1: After reset every protection bit is 0, the cause register reads 0, the fault address reads 0 and `err_irq` is low.
- R2: A configuration write to index 4+j loads map word j, which holds the bits for registers 32j to 32j+31 (bit k of the word belongs to register 32j+k). A read at the same index returns that word.
- R3: A configuration write to index 2 with data D sets the map bit at index D>>2 when D is 4-byte aligned and below the window size in bytes. Any other D leaves the map unchanged.
- R4: An access to a register whose map bit is 0 is checked for privilege and security. For a read, a missing privileged flag sets cause bit 0 and a missing secure flag sets bit 1. For a write, a missing privileged flag sets bit 3. A missing secure flag on a write sets bit 4, or bit 6 when the external-interface flag is high.
- R5: An access to a register whose map bit is 1 raises no privilege or security cause, whatever its flags.
- R6: An access whose address is below BLOCK_BASE, or at or above BLOCK_BASE plus the window size, is unmapped. A read sets cause bit 2. A write sets bit 5, or bit 7 when the external-interface flag is high.
- R7: A read of a register listed as write-only sets cause bit 8, and a write to a register listed as read-only sets bit 9. Both hold regardless of the map bit.
- R8: An access with no cause bit is granted (`acc_grant`=1, `acc_deny`=0) and carries the register file's read data. An access with any cause bit is denied: `acc_grant`=0, `acc_deny`=1, `bus_rdata`=0.
- R9: When the cause register is zero, a fault latches its address into the fault address register (index 1). While the cause register stays nonzero, later faults only OR in their cause bits and leave the address unchanged.
- R10: A configuration write to index 0 clears exactly the cause bits that are set in the written data. Once the cause register reaches zero, the next fault latches its address again.
- R11: `err_irq` is high exactly while the cause register is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 1 | Caller is privileged |
| req_secure | input | 1 | Caller is secure |
| req_ext | input | 1 | Access arrives from the external interface |
| acc_grant | output | 1 | Access allowed through to the register file |
| acc_deny | output | 1 | Access blocked |
| rf_rdata | input | 32 | Read data from the register file |
| bus_rdata | output | 32 | Read data returned to the caller |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | Configuration write when high |
| cfg_idx | input | CFG_AW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| err_irq | output | 1 | High while any cause bit is set |

## Verification
The bench targets four behaviours. The first is the address held across a second fault: a design that overwrote it would report the newest fault instead of the first. The second is the partial write-one-to-clear: a design that cleared the whole register, or re-armed address capture too early, would lose a pending cause or move the address. The third covers the window edges, one word below the base and the first byte past the end, where an off-by-one compare would grant an unmapped access. The fourth covers open-by-offset with misaligned and out-of-range data, where a design that truncated the offset would silently open the wrong register. The bench also checks the split between the external and internal security causes, and direction faults on registers that are already open.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

   localparam int CAUSE_W = 10;

   // cause bit positions; software decodes these
   localparam int C_RD_UNPRIV   = 0;
   localparam int C_RD_UNSEC    = 1;
   localparam int C_RD_UNMAP    = 2;
   localparam int C_WR_UNPRIV   = 3;
   localparam int C_WR_UNSEC    = 4;
   localparam int C_WR_UNMAP    = 5;
   localparam int C_EXT_UNSEC   = 6;
   localparam int C_EXT_UNMAP   = 7;
   localparam int C_RD_WONLY    = 8;
   localparam int C_WR_RONLY    = 9;

   // configuration word indices
   localparam int CFG_IDX_CAUSE = 0;
   localparam int CFG_IDX_FADDR = 1;
   localparam int CFG_IDX_OPEN  = 2;
   localparam int CFG_IDX_MAP0  = 4;

   typedef logic [CAUSE_W-1:0] cause_t;

endpackage

// File: rtl/regguard_map.sv
module regguard_map
   import regguard_pkg::*;
#(
   parameter int NUM_REGS = 64,
   localparam int MAP_WORDS = NUM_REGS / 32,
   localparam int IDX_W = $clog2(NUM_REGS),
   localparam int WSEL_W = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1,
   localparam int BLOCK_BYTES = NUM_REGS * 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_word_en,
   input  logic [WSEL_W-1:0]    wr_word_sel,
   input  logic [31:0]          wr_word_data,
   input  logic                 open_en,
   input  logic [31:0]          open_off,
   output logic [NUM_REGS-1:0]  map_bits
);

   initial begin
      assert (NUM_REGS >= 32 && NUM_REGS % 32 == 0)
         else $error("NUM_REGS must be a nonzero multiple of 32");
   end

   logic             open_ok;
   logic [IDX_W-1:0] open_idx;

   always_comb begin
      open_ok  = open_en && (open_off[1:0] == 2'b00) && (open_off < 32'(BLOCK_BYTES));
      open_idx = open_off[IDX_W+1:2];
   end

   for (genvar j = 0; j < MAP_WORDS; j++) begin : g_word
      logic [31:0] word_q;
      logic        hit_word;
      logic        hit_open;

      always_comb begin
         hit_word = wr_word_en && (int'(wr_word_sel) == j);
         hit_open = open_ok && (int'(open_idx >> 5) == j);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (hit_word) begin
            word_q <= wr_word_data;
         end else if (hit_open) begin
            word_q[open_idx[4:0]] <= 1'b1;
         end
      end

      assign map_bits[j*32 +: 32] = word_q;
   end

   AST_BAD_OPEN_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (open_en && !wr_word_en && ((open_off[1:0] != 2'b00) || (open_off >= 32'(BLOCK_BYTES))))
      |=> $stable(map_bits)) else $error("bad open changed map"); // R3

endmodule

// File: rtl/regguard_classify.sv
module regguard_classify
   import regguard_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          NUM_REGS   = 64,
   parameter logic [ADDR_W-1:0] BLOCK_BASE = 16'h1000,
   parameter bit          DIR_CHECK_EN = 1'b1,
   parameter logic [NUM_REGS-1:0] RO_MAP = '0,
   parameter logic [NUM_REGS-1:0] WO_MAP = '0,
   localparam int IDX_W = $clog2(NUM_REGS),
   localparam int BLOCK_BYTES = NUM_REGS * 4
)(
   input  logic                 req_valid,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic                 req_write,
   input  logic                 req_priv,
   input  logic                 req_secure,
   input  logic                 req_ext,
   input  logic [NUM_REGS-1:0]  map_bits,
   output cause_t               cause_bits,
   output logic                 in_window,
   output logic                 reg_open
);

   initial begin
      assert (ADDR_W > IDX_W + 2) else $error("ADDR_W too small for window");
      assert ({1'b0, BLOCK_BASE} + (ADDR_W+1)'(BLOCK_BYTES) <= (ADDR_W+1)'(2**ADDR_W))
         else $error("window runs past the address space");
   end

   logic [ADDR_W:0]   lo_ext, hi_ext, a_ext;
   logic [ADDR_W-1:0] rel;
   logic [IDX_W-1:0]  idx;
   cause_t            c_acc, c_dir;

   always_comb begin
      a_ext     = {1'b0, req_addr};
      lo_ext    = {1'b0, BLOCK_BASE};
      hi_ext    = lo_ext + (ADDR_W+1)'(BLOCK_BYTES);
      in_window = (a_ext >= lo_ext) && (a_ext < hi_ext);
      rel       = req_addr - BLOCK_BASE;
      idx       = rel[IDX_W+1:2];
      reg_open  = map_bits[idx];
   end

   // privilege, security and mapping
   always_comb begin
      c_acc = '0;
      if (!in_window) begin
         if (!req_write)   c_acc[C_RD_UNMAP] = 1'b1;
         else if (req_ext) c_acc[C_EXT_UNMAP] = 1'b1;
         else              c_acc[C_WR_UNMAP] = 1'b1;
      end else if (!reg_open) begin
         if (!req_write) begin
            c_acc[C_RD_UNPRIV] = !req_priv;
            c_acc[C_RD_UNSEC]  = !req_secure;
         end else begin
            c_acc[C_WR_UNPRIV] = !req_priv;
            if (req_ext) c_acc[C_EXT_UNSEC] = !req_secure;
            else         c_acc[C_WR_UNSEC]  = !req_secure;
         end
      end
   end

   // direction checks, present only when enabled
   if (DIR_CHECK_EN) begin : g_dir
      always_comb begin
         c_dir = '0;
         if (in_window) begin
            c_dir[C_RD_WONLY] = !req_write && WO_MAP[idx];
            c_dir[C_WR_RONLY] = req_write && RO_MAP[idx];
         end
      end
   end else begin : g_nodir
      assign c_dir = '0;
   end

   assign cause_bits = req_valid ? (c_acc | c_dir) : '0;

endmodule

// File: rtl/regguard_status.sv
module regguard_status
   import regguard_pkg::*;
#(
   parameter int ADDR_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_valid,
   input  cause_t            fault_bits,
   input  logic [ADDR_W-1:0] fault_addr_in,
   input  logic              clr_en,
   input  cause_t            clr_bits,
   output cause_t            cause_q,
   output logic [ADDR_W-1:0] fault_addr_q
);

   cause_t kept, nxt;
   logic   capture;

   always_comb begin
      kept    = cause_q & ~(clr_en ? clr_bits : cause_t'('0));
      nxt     = kept | (fault_valid ? fault_bits : cause_t'('0));
      capture = fault_valid && (fault_bits != '0) && (kept == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q      <= '0;
         fault_addr_q <= '0;
      end else begin
         cause_q <= nxt;
         if (capture) fault_addr_q <= fault_addr_in;
      end
   end

   AST_FIRST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && (cause_q == '0) && !clr_en) |=> (fault_addr_q == $past(fault_addr_in)))
      else $error("first fault address not latched"); // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause_q != '0) && !clr_en) |=> $stable(fault_addr_q))
      else $error("fault address moved while pending"); // R9
   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> ((cause_q & $past(cause_q)) == $past(cause_q)))
      else $error("cause bit dropped without clear"); // R10

endmodule

// File: rtl/regguard_top.sv
module regguard_top
   import regguard_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          NUM_REGS   = 64,
   parameter int          CFG_AW     = 4,
   parameter logic [ADDR_W-1:0] BLOCK_BASE = 16'h1000,
   parameter bit          DIR_CHECK_EN = 1'b1,
   parameter logic [NUM_REGS-1:0] RO_MAP = 64'h0000_0000_0000_0020,
   parameter logic [NUM_REGS-1:0] WO_MAP = 64'h0000_0000_0000_0040
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic              req_secure,
   input  logic              req_ext,
   output logic              acc_grant,
   output logic              acc_deny,
   input  logic [31:0]       rf_rdata,
   output logic [31:0]       bus_rdata,
   input  logic              cfg_valid,
   input  logic              cfg_write,
   input  logic [CFG_AW-1:0] cfg_idx,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              err_irq
);

   localparam int MAP_WORDS = NUM_REGS / 32;
   localparam int WSEL_W    = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;

   initial begin
      assert (CFG_IDX_MAP0 + MAP_WORDS <= 2**CFG_AW)
         else $error("CFG_AW too small for the map words");
      assert (ADDR_W <= 32) else $error("ADDR_W wider than config data");
   end

   logic [NUM_REGS-1:0] map_bits;
   cause_t              cause_bits, cause_q;
   logic [ADDR_W-1:0]   fault_addr_q;
   logic                in_window, reg_open;
   logic                cfg_wr, wr_word_en, open_en, clr_en;
   logic [WSEL_W-1:0]   wr_word_sel;
   logic                is_map_idx;
   int                  map_off;

   always_comb begin
      cfg_wr      = cfg_valid && cfg_write;
      map_off     = int'(cfg_idx) - CFG_IDX_MAP0;
      is_map_idx  = (map_off >= 0) && (map_off < MAP_WORDS);
      wr_word_en  = cfg_wr && is_map_idx;
      wr_word_sel = WSEL_W'(map_off);
      open_en     = cfg_wr && (int'(cfg_idx) == CFG_IDX_OPEN);
      clr_en      = cfg_wr && (int'(cfg_idx) == CFG_IDX_CAUSE);
   end

   regguard_map #(.NUM_REGS(NUM_REGS)) u_map (
      .clk(clk), .rst_n(rst_n),
      .wr_word_en(wr_word_en), .wr_word_sel(wr_word_sel), .wr_word_data(cfg_wdata),
      .open_en(open_en), .open_off(cfg_wdata),
      .map_bits(map_bits)
   );

   regguard_classify #(
      .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BLOCK_BASE(BLOCK_BASE),
      .DIR_CHECK_EN(DIR_CHECK_EN), .RO_MAP(RO_MAP), .WO_MAP(WO_MAP)
   ) u_cls (
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_priv(req_priv), .req_secure(req_secure), .req_ext(req_ext),
      .map_bits(map_bits), .cause_bits(cause_bits),
      .in_window(in_window), .reg_open(reg_open)
   );

   regguard_status #(.ADDR_W(ADDR_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .fault_valid(req_valid && (cause_bits != '0)), .fault_bits(cause_bits),
      .fault_addr_in(req_addr),
      .clr_en(clr_en), .clr_bits(cfg_wdata[CAUSE_W-1:0]),
      .cause_q(cause_q), .fault_addr_q(fault_addr_q)
   );

   always_comb begin
      acc_grant = req_valid && (cause_bits == '0);
      acc_deny  = req_valid && (cause_bits != '0);
      bus_rdata = (acc_grant && !req_write) ? rf_rdata : 32'h0;
      err_irq   = (cause_q != '0);
   end

   always_comb begin
      cfg_rdata = 32'h0;
      if (is_map_idx)                              cfg_rdata = map_bits[map_off*32 +: 32];
      else if (int'(cfg_idx) == CFG_IDX_CAUSE)     cfg_rdata = 32'(cause_q);
      else if (int'(cfg_idx) == CFG_IDX_FADDR)     cfg_rdata = 32'(fault_addr_q);
   end

   AST_GRANT_XOR_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (acc_grant != acc_deny)) else $error("grant and deny agree"); // R8
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!acc_grant && !acc_deny)) else $error("response without request"); // R8
   AST_OPEN_NO_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_window && reg_open) |->
      (cause_bits[C_RD_UNPRIV] == 1'b0 && cause_bits[C_RD_UNSEC] == 1'b0 &&
       cause_bits[C_WR_UNPRIV] == 1'b0 && cause_bits[C_WR_UNSEC] == 1'b0 &&
       cause_bits[C_EXT_UNSEC] == 1'b0)) else $error("open register faulted"); // R5
   AST_IRQ_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_deny && !clr_en) |=> err_irq) else $error("irq missing after fault"); // R11

endmodule

// File: tb/regguard_top_bench.sv
module regguard_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0, req_ext = 1'b0;
   logic [15:0] req_addr = '0;
   logic        acc_grant, acc_deny, err_irq;
   logic [31:0] rf_rdata, bus_rdata, cfg_rdata;
   logic        cfg_valid = 1'b0, cfg_write = 1'b0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct { logic grant; logic [31:0] rdata; string tag; } exp_t;
   exp_t sbq[$];

   always #5 clk = ~clk;

   assign rf_rdata = {16'hBEEF, req_addr};

   regguard_top u_regguard_top (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_priv(req_priv), .req_secure(req_secure), .req_ext(req_ext),
      .acc_grant(acc_grant), .acc_deny(acc_deny),
      .rf_rdata(rf_rdata), .bus_rdata(bus_rdata),
      .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_irq(err_irq)
   );

   // monitor: pops expected results as requests appear
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (req_valid && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (acc_grant !== e.grant || acc_deny !== !e.grant || bus_rdata !== e.rdata) begin
               errors++;
               $display("FAIL %s: grant=%b deny=%b rdata=%h expected grant=%b rdata=%h",
                        e.tag, acc_grant, acc_deny, bus_rdata, e.grant, e.rdata);
            end
         end
      end
   end

   task automatic access(input logic [15:0] a, input logic wr, input logic pv,
                         input logic sc, input logic ex, input logic g, input string tag);
      exp_t e;
      @(negedge clk);
      req_addr = a; req_write = wr; req_priv = pv; req_secure = sc; req_ext = ex;
      req_valid = 1'b1;
      e.grant = g;
      e.rdata = (g && !wr) ? {16'hBEEF, a} : 32'h0;
      e.tag = tag;
      sbq.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic cfg_wr(input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
   endtask

   task automatic cfg_chk(input logic [3:0] idx, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_idx = idx;
      #1;
      checks++;
      if (cfg_rdata !== exp) begin
         errors++;
         $display("FAIL %s: cfg[%0d]=%h expected %h", tag, idx, cfg_rdata, exp);
      end
      cfg_valid = 1'b0;
   endtask

   task automatic irq_chk(input logic exp, input string tag);
      @(negedge clk);
      #1;
      checks++;
      if (err_irq !== exp) begin
         errors++;
         $display("FAIL %s: err_irq=%b expected %b", tag, err_irq, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cfg_chk(0, 32'h0, "R1 cause");
      cfg_chk(1, 32'h0, "R1 faddr");
      cfg_chk(4, 32'h0, "R1 map0");
      cfg_chk(5, 32'h0, "R1 map1");
      irq_chk(1'b0, "R1 irq");
      // R8 granted trusted read
      access(16'h100C, 0, 1, 1, 0, 1, "R8 trusted read");
      cfg_chk(0, 32'h0, "R8 no cause");
      // R4 unprivileged read of protected reg
      access(16'h100C, 0, 0, 1, 0, 0, "R4 unpriv read");
      cfg_chk(0, 32'h001, "R4 cause bit0");
      cfg_chk(1, 32'h100C, "R9 first addr");
      irq_chk(1'b1, "R11 irq set");
      // R9 second fault ORs in, address held
      access(16'h1010, 1, 1, 0, 0, 0, "R4 nonsecure write");
      cfg_chk(0, 32'h011, "R9 cause or");
      cfg_chk(1, 32'h100C, "R9 addr held");
      // R10 partial clear
      cfg_wr(0, 32'h001);
      cfg_chk(0, 32'h010, "R10 partial clear");
      cfg_chk(1, 32'h100C, "R10 addr kept");
      irq_chk(1'b1, "R11 irq still set");
      cfg_wr(0, 32'h010);
      cfg_chk(0, 32'h000, "R10 full clear");
      irq_chk(1'b0, "R11 irq clear");
      // R4 external nonsecure write, address re-armed
      access(16'h1010, 1, 1, 0, 1, 0, "R4 ext nonsecure write");
      cfg_chk(0, 32'h040, "R4 cause bit6");
      cfg_chk(1, 32'h1010, "R10 re-armed addr");
      cfg_wr(0, 32'h3FF);
      // R6 unmapped, at window edges
      access(16'h1100, 0, 1, 1, 0, 0, "R6 read past end");
      cfg_chk(0, 32'h004, "R6 cause bit2");
      cfg_wr(0, 32'h004);
      access(16'h0FFC, 1, 1, 1, 0, 0, "R6 write below base");
      cfg_chk(0, 32'h020, "R6 cause bit5");
      cfg_wr(0, 32'h020);
      access(16'h1100, 1, 1, 1, 1, 0, "R6 ext write past end");
      cfg_chk(0, 32'h080, "R6 cause bit7");
      cfg_wr(0, 32'h080);
      access(16'h10FC, 0, 1, 1, 0, 1, "R6 last word mapped");
      // R3 open by offset, plus ignored offsets
      cfg_wr(2, 32'h0000_000C);
      cfg_chk(4, 32'h0000_0008, "R3 open reg3");
      cfg_wr(2, 32'h0000_000D);
      cfg_chk(4, 32'h0000_0008, "R3 misaligned ignored");
      cfg_wr(2, 32'h0000_0100);
      cfg_chk(4, 32'h0000_0008, "R3 out of range ignored");
      cfg_chk(5, 32'h0000_0000, "R3 map1 untouched");
      // R5 open register ignores flags
      access(16'h100C, 0, 0, 0, 0, 1, "R5 open unpriv read");
      access(16'h100C, 1, 0, 0, 1, 1, "R5 open ext write");
      cfg_chk(0, 32'h0, "R5 no cause");
      // R2 word programming
      cfg_wr(5, 32'h0000_0001);
      cfg_chk(5, 32'h0000_0001, "R2 map1 readback");
      access(16'h1080, 1, 0, 0, 0, 1, "R2 reg32 open");
      access(16'h1084, 1, 0, 1, 0, 0, "R2 reg33 protected");
      cfg_chk(0, 32'h008, "R2 cause bit3");
      cfg_wr(0, 32'h008);
      // R7 direction faults, even on open registers
      cfg_wr(4, 32'h0000_0060);
      access(16'h1018, 0, 1, 1, 0, 0, "R7 read write-only");
      cfg_chk(0, 32'h100, "R7 cause bit8");
      access(16'h1014, 1, 0, 0, 0, 0, "R7 write read-only");
      cfg_chk(0, 32'h300, "R7 cause bit9");
      cfg_chk(1, 32'h1018, "R9 addr first dir fault");
      access(16'h1014, 0, 1, 1, 0, 1, "R7 read read-only ok");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule